// File: doc/BRIEF.md
# Banked Offset and Gain Correction Unit

This block sits after the decimation filter of a measurement converter. It corrects every raw conversion result it receives. It subtracts a signed offset, multiplies by an unsigned fixed-point gain, and returns a saturated signed result. Four independent coefficient pairs are stored, each pair made of one offset and one gain. The pair used for a sample is chosen in the cycle that sample arrives. Channel sequencing logic can therefore apply a different correction to each input channel, or pin all samples to one pair.

Coefficients are loaded only through a direct register port. The port has a kind bit (offset or gain), a two-bit bank index, write data and a combinational read-back. The datapath is a two-register pipeline, so a corrected result appears a fixed two cycles after its raw sample. A new sample can enter every cycle.

Top module: `cal_bank_unit`

## Requirements
- R1: After synchronous reset every offset register reads 0x00000000 and every gain register reads 0x01000000. While reset is held, out_valid is low.
- R2: When cfg_we is high, cfg_wdata is written to the register named by cfg_kind and cfg_bank. cfg_kind 0 selects an offset and 1 selects a gain; cfg_bank picks one of four banks. cfg_rdata always shows the register named by cfg_kind and cfg_bank. A write changes only the register it names.
- R3: The result is floor(((raw − offset) × gain) / 2^24). raw and offset are signed 32-bit values, and the subtraction is done without wrap. gain is an unsigned 32-bit value with 24 fractional bits, so 0x01000000 is unity. Negative fractions round toward minus infinity.
- R4: A result above 0x7FFFFFFF is output as 0x7FFFFFFF. A result below −2^31 is output as 0x80000000.
- R5: out_valid is high for exactly one cycle, two cycles after each cycle in which in_valid is high, and at no other time. out_data keeps its value while out_valid is low.
- R6: When pair_mode is 1, the pair used for a sample is chan_pair. When pair_mode is 0, it is pair_fixed. Both are sampled in the same cycle as in_valid.
- R7: A coefficient write in the same cycle as an accepted sample does not affect that sample. The new value applies from the next sample onward.
- R8: Samples presented in consecutive cycles, each using a different pair, each produce their own correct result, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_kind | input | 1 | 0 = offset register, 1 = gain register |
| cfg_bank | input | 2 | Coefficient bank index for read and write |
| cfg_wdata | input | 32 | Coefficient write data |
| cfg_rdata | output | 32 | Read-back of the addressed coefficient |
| pair_mode | input | 1 | 1 = use chan_pair, 0 = use pair_fixed |
| pair_fixed | input | 2 | Pair used when pair_mode is 0 |
| chan_pair | input | 2 | Pair supplied by channel control |
| in_valid | input | 1 | Raw sample strobe |
| in_raw | input | 32 | Raw signed sample |
| out_valid | output | 1 | Corrected sample strobe |
| out_data | output | 32 | Corrected signed sample |

## Verification
The bench feeds back-to-back samples that cycle through all four pairs in both selection modes. A design that latched the pair one cycle late, or ignored pair_mode, would produce results from the wrong bank. A raw maximum with an offset of −1 needs a 33-bit difference: a design that wraps the difference would output 0x80000000 instead of 0x7FFFFFFF. Other cases drive the product past both signed limits, which a non-saturating design would wrap. A case with a result of −0.5 must give −1; a design that truncates toward zero would give 0. A gain write in the same cycle as a sample must leave that sample on the old gain. A design without a coefficient snapshot would apply the new gain early.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int unsigned CAL_DATA_W = 32;
    localparam int unsigned CAL_FRAC_W = 24;
    localparam int unsigned CAL_PAIRS  = 4;

    typedef enum logic {
        COEF_OFFSET = 1'b0,
        COEF_GAIN   = 1'b1
    } coef_kind_e;

    // Unity gain in the fixed-point format: one shifted up by the fraction width
    function automatic logic [63:0] unity_gain(input int unsigned frac_w);
        return 64'd1 << frac_w;
    endfunction

endpackage

// File: rtl/cal_coef_bank.sv
module cal_coef_bank
    import cal_pkg::*;
#(
    parameter int unsigned DATA_W = CAL_DATA_W,
    parameter int unsigned FRAC_W = CAL_FRAC_W,
    parameter int unsigned PAIRS  = CAL_PAIRS,
    localparam int unsigned BW    = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  coef_kind_e        acc_kind,
    input  logic [BW-1:0]     acc_bank,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [BW-1:0]     sel_idx,
    output logic [DATA_W-1:0] sel_off,
    output logic [DATA_W-1:0] sel_gain
);

    localparam logic [63:0]       UNITY64    = unity_gain(FRAC_W);
    localparam logic [DATA_W-1:0] GAIN_RESET = UNITY64[DATA_W-1:0];

    logic [DATA_W-1:0] off_arr  [PAIRS];
    logic [DATA_W-1:0] gain_arr [PAIRS];

    for (genvar g = 0; g < PAIRS; g++) begin : g_bank
        logic [DATA_W-1:0] off_r;
        logic [DATA_W-1:0] gain_r;
        logic              hit;

        assign hit = wr_en && (acc_bank == BW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                off_r  <= '0;
                gain_r <= GAIN_RESET;
            end else if (hit) begin
                if (acc_kind == COEF_OFFSET) off_r  <= wr_data;
                else                         gain_r <= wr_data;
            end
        end

        assign off_arr[g]  = off_r;
        assign gain_arr[g] = gain_r;
    end

    always_comb begin
        if (acc_kind == COEF_OFFSET) rd_data = off_arr[acc_bank];
        else                         rd_data = gain_arr[acc_bank];
    end

    assign sel_off  = off_arr[sel_idx];
    assign sel_gain = gain_arr[sel_idx];

endmodule

// File: rtl/cal_pair_select.sv
module cal_pair_select #(
    parameter int unsigned BW = 2
) (
    input  logic          per_channel,
    input  logic [BW-1:0] fixed_idx,
    input  logic [BW-1:0] chan_idx,
    output logic [BW-1:0] pair_idx
);

    always_comb begin
        pair_idx = per_channel ? chan_idx : fixed_idx;
    end

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
    import cal_pkg::*;
#(
    parameter int unsigned DATA_W = CAL_DATA_W,
    parameter int unsigned FRAC_W = CAL_FRAC_W,
    localparam int unsigned DW    = DATA_W + 1,
    localparam int unsigned PW    = 2 * DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_raw,
    input  logic [DATA_W-1:0] coef_off,
    input  logic [DATA_W-1:0] coef_gain,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    typedef struct packed {
        logic                 valid;
        logic signed [DW-1:0] diff;
        logic [DATA_W-1:0]    gain;
    } stage1_t;

    localparam logic signed [PW-1:0] SAT_HI = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PW-1:0] SAT_LO = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    stage1_t               s1_q;
    logic signed [DW-1:0]  diff_c;
    logic signed [PW-1:0]  prod_c;
    logic signed [PW-1:0]  scaled_c;
    logic [DATA_W-1:0]     clamp_c;

    // Stage 1: widened subtraction and coefficient snapshot
    assign diff_c = $signed({in_raw[DATA_W-1], in_raw}) - $signed({coef_off[DATA_W-1], coef_off});

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.valid <= in_valid;
            if (in_valid) begin
                s1_q.diff <= diff_c;
                s1_q.gain <= coef_gain;
            end
        end
    end

    // Stage 2: scale, drop fraction bits with floor, clamp
    assign prod_c   = $signed(PW'(s1_q.diff)) * $signed(PW'($signed({1'b0, s1_q.gain})));
    assign scaled_c = prod_c >>> FRAC_W;

    always_comb begin
        if (scaled_c > SAT_HI)      clamp_c = SAT_HI[DATA_W-1:0];
        else if (scaled_c < SAT_LO) clamp_c = SAT_LO[DATA_W-1:0];
        else                        clamp_c = scaled_c[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_q.valid;
            if (s1_q.valid) out_data <= clamp_c;
        end
    end

endmodule

// File: rtl/cal_bank_unit.sv
module cal_bank_unit
    import cal_pkg::*;
#(
    parameter int unsigned DATA_W = CAL_DATA_W,
    parameter int unsigned FRAC_W = CAL_FRAC_W,
    parameter int unsigned PAIRS  = CAL_PAIRS,
    localparam int unsigned BW    = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_kind,
    input  logic [BW-1:0]     cfg_bank,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              pair_mode,
    input  logic [BW-1:0]     pair_fixed,
    input  logic [BW-1:0]     chan_pair,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_raw,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [BW-1:0]     pair_idx;
    logic [DATA_W-1:0] sel_off;
    logic [DATA_W-1:0] sel_gain;
    coef_kind_e        kind_e;

    assign kind_e = coef_kind_e'(cfg_kind);

    cal_pair_select #(.BW(BW)) pair_sel_i (
        .per_channel (pair_mode),
        .fixed_idx   (pair_fixed),
        .chan_idx    (chan_pair),
        .pair_idx    (pair_idx)
    );

    cal_coef_bank #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .PAIRS(PAIRS)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .acc_kind (kind_e),
        .acc_bank (cfg_bank),
        .wr_data  (cfg_wdata),
        .rd_data  (cfg_rdata),
        .sel_idx  (pair_idx),
        .sel_off  (sel_off),
        .sel_gain (sel_gain)
    );

    cal_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) dp_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_raw    (in_raw),
        .coef_off  (sel_off),
        .coef_gain (sel_gain),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/cal_bank_unit_chk.sv
module cal_bank_unit_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BW     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              cfg_kind,
    input logic [BW-1:0]     cfg_bank,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                    since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R5: each accepted sample yields a result two cycles later
    p_latency_fwd_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    // R5: no result without a sample two cycles earlier
    p_latency_back_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && since_rst == 2'd3) |-> $past(in_valid, 2));

    // R5: output data is held between results
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R1: pipeline is empty on leaving reset
    p_quiet_r1: assert property (@(posedge clk)
        $fell(rst) |-> !out_valid);

    // R2: a written coefficient reads back at the same address
    p_rdwr_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (!($stable(cfg_kind) && $stable(cfg_bank)) || cfg_rdata == $past(cfg_wdata)));

endmodule

bind cal_bank_unit cal_bank_unit_chk #(.DATA_W(DATA_W), .BW(BW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_kind  (cfg_kind),
    .cfg_bank  (cfg_bank),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/cal_bank_unit_tb_top.sv
module cal_bank_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_kind = 1'b0;
    logic [1:0]  cfg_bank = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pair_mode = 1'b1;
    logic [1:0]  pair_fixed = '0;
    logic [1:0]  chan_pair = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_raw = '0;
    logic        out_valid;
    logic [31:0] out_data;

    always #5 clk = ~clk;

    cal_bank_unit dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_bank(cfg_bank),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pair_mode(pair_mode),
        .pair_fixed(pair_fixed), .chan_pair(chan_pair), .in_valid(in_valid),
        .in_raw(in_raw), .out_valid(out_valid), .out_data(out_data)
    );

    typedef struct {
        logic [31:0] data;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] m_off  [4];
    logic [31:0] m_gain [4];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] model(input logic [31:0] raw, input logic [31:0] off,
                                          input logic [31:0] gain);
        logic signed [95:0] d, p, s;
        logic signed [95:0] hi, lo;
        hi = 96'sd2147483647;
        lo = -96'sd2147483648;
        d = 96'($signed(raw)) - 96'($signed(off));
        p = d * $signed({64'd0, gain});
        s = p >>> 24;
        if (s > hi) return 32'h7FFF_FFFF;
        if (s < lo) return 32'h8000_0000;
        return s[31:0];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus: optional coefficient write and optional sample
    task automatic step(input bit do_wr, input bit kind, input logic [1:0] bank, input logic [31:0] wd,
                        input bit do_smp, input logic [31:0] raw, input bit mode,
                        input logic [1:0] fixed, input logic [1:0] chan, input string tag);
        exp_t e;
        logic [1:0] p;
        @(negedge clk);
        cfg_we = do_wr; cfg_kind = kind; cfg_bank = bank; cfg_wdata = wd;
        in_valid = do_smp; in_raw = raw; pair_mode = mode; pair_fixed = fixed; chan_pair = chan;
        if (do_smp) begin
            p = mode ? chan : fixed;
            e.data = model(raw, m_off[p], m_gain[p]);
            e.cyc  = cyc + 2;
            e.tag  = tag;
            sb_q.push_back(e);
        end
        if (do_wr) begin
            if (kind) m_gain[bank] = wd;
            else      m_off[bank]  = wd;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_we = 1'b0; in_valid = 1'b0;
        end
    endtask

    task automatic rd_check(input bit kind, input logic [1:0] bank, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0; cfg_kind = kind; cfg_bank = bank;
        #1;
        check(cfg_rdata === exp, tag, cfg_rdata, exp);
    endtask

    // Monitor: compare each result with the scoreboard head
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R5 unexpected result", out_data, 32'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(out_data === e.data, e.tag, out_data, e.data);
                check(cyc == e.cyc, {e.tag, " R5 latency"}, 32'(cyc), 32'(e.cyc));
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_off[i]  = 32'h0;
            m_gain[i] = 32'h0100_0000;
        end
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 out_valid in reset", {31'd0, out_valid}, 32'h0);
        rst = 1'b0;
        // R1: reset values of all banks
        for (int b = 0; b < 4; b++) begin
            rd_check(1'b0, 2'(b), 32'h0000_0000, "R1 offset reset");
            rd_check(1'b1, 2'(b), 32'h0100_0000, "R1 gain reset");
        end
        // R3: unity passthrough with reset coefficients
        step(0, 0, 0, 0, 1, 32'd12345, 1, 0, 2'd0, "R3 unity");
        step(0, 0, 0, 0, 1, 32'hFFFF_FF00, 1, 0, 2'd3, "R3 unity negative");
        idle(4);
        // R2: load distinct pairs
        step(1, 0, 2'd1, 32'd100,        0, 0, 1, 0, 0, "");
        step(1, 1, 2'd1, 32'h0200_0000,  0, 0, 1, 0, 0, "");
        step(1, 0, 2'd2, 32'hFFFF_FFFB,  0, 0, 1, 0, 0, "");
        step(1, 1, 2'd2, 32'h0080_0000,  0, 0, 1, 0, 0, "");
        step(1, 0, 2'd3, 32'h4000_0000,  0, 0, 1, 0, 0, "");
        step(1, 1, 2'd3, 32'h0300_0000,  0, 0, 1, 0, 0, "");
        rd_check(1'b0, 2'd1, 32'd100,       "R2 offset bank1");
        rd_check(1'b1, 2'd2, 32'h0080_0000, "R2 gain bank2");
        rd_check(1'b0, 2'd3, 32'h4000_0000, "R2 offset bank3");
        rd_check(1'b0, 2'd0, 32'h0,         "R2 bank0 offset untouched");
        rd_check(1'b1, 2'd0, 32'h0100_0000, "R2 bank0 gain untouched");
        // R8 and R6: back-to-back samples through every pair, channel mode
        step(0, 0, 0, 0, 1, 32'd1000, 1, 2'd0, 2'd0, "R8 R6 pair0");
        step(0, 0, 0, 0, 1, 32'd1000, 1, 2'd0, 2'd1, "R8 R6 pair1");
        step(0, 0, 0, 0, 1, 32'd1000, 1, 2'd0, 2'd2, "R8 R6 pair2");
        step(0, 0, 0, 0, 1, 32'd1000, 1, 2'd0, 2'd3, "R4 negative clamp pair3");
        // R6: fixed mode ignores chan_pair
        step(0, 0, 0, 0, 1, 32'd1000, 0, 2'd2, 2'd3, "R6 fixed pair2");
        step(0, 0, 0, 0, 1, 32'd4000, 0, 2'd1, 2'd0, "R6 fixed pair1");
        // R3: floor of a negative half
        step(0, 0, 0, 0, 1, 32'hFFFF_FFFA, 1, 0, 2'd2, "R3 floor minus half");
        // R4: positive clamp through the product
        step(0, 0, 0, 0, 1, 32'h7FFF_FFF0, 1, 0, 2'd1, "R4 positive clamp");
        idle(3);
        // R4: 33-bit difference before clamping
        step(1, 0, 2'd0, 32'hFFFF_FFFF, 0, 0, 1, 0, 0, "");
        step(0, 0, 0, 0, 1, 32'h7FFF_FFFF, 1, 0, 2'd0, "R4 wide difference");
        step(0, 0, 0, 0, 1, 32'h8000_0000, 1, 0, 2'd2, "R3 minimum raw");
        // R7: same-cycle write uses the old gain, next sample the new one
        step(1, 1, 2'd1, 32'h0100_0000, 1, 32'd300, 1, 0, 2'd1, "R7 old gain");
        step(0, 0, 0, 0, 1, 32'd300, 1, 0, 2'd1, "R7 new gain");
        idle(4);
        // R5: quiet and held output while idle
        begin
            logic [31:0] held;
            held = out_data;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                check(out_valid === 1'b0, "R5 idle valid", {31'd0, out_valid}, 32'h0);
                check(out_data === held, "R5 idle hold", out_data, held);
            end
        end
        check(sb_q.size() == 0, "R5 results missing", 32'(sb_q.size()), 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule